// File: doc/BRIEF.md
# Segment Address Extension Unit

This unit sits on one core's outbound memory path. It turns a 32-bit logical address into a 36-bit physical address, so the core can reach a physical space larger than 4 GB. It also checks access permissions in the same lookup. Each core gets its own instance, with a private set of sixteen 64-bit segment descriptors. Two cores can therefore map the same logical address onto different physical memory. For example, four cores can each own a 2 GB slice of an 8 GB external space.

Each descriptor names an aligned logical window of power-of-two size, a physical base for that window, and six permission bits. The six bits are read, write and execute, once for user mode and once for supervisor mode. A lookup presents an address, an access kind and a privilege flag. One clock later the unit returns either a translated address with a hit flag, or a fault with a zero address. When windows overlap, the descriptor with the higher index wins. Software programs each descriptor as two 32-bit halves through a simple write port.

Top module: `seg_xlate`

## Requirements
- R1: There are 16 descriptors. Each is written as two 32-bit halves: `cfg_hi`=0 selects the lower half and `cfg_hi`=1 the upper half, for descriptor `cfg_idx`, when `cfg_we` is high. A write is seen by lookups issued in the following cycle and later. A lookup issued in the same cycle as the write uses the old contents.
- R2: The lower half holds the logical base in bits [31:12] and the size code in bits [4:0].
- R3: The upper half holds physical address bits [35:12] in its bits [31:8], and the permissions in bits [5:0]. Permission bit 0 is user read, 1 user write, 2 user execute, 3 supervisor read, 4 supervisor write and 5 supervisor execute.
- R4: A size code c from 11 to 31 makes a segment of 2^(c+1) bytes, so the range runs from 4 KB to 4 GB. Any code from 0 to 10 disables the descriptor.
- R5: An address matches an enabled descriptor when it agrees with the logical base above the segment size. On a hit, the physical address is the physical base above the segment size, with the address offset inside the segment carried through unchanged. Physical bits above bit 31 can be reached this way.
- R6: When several descriptors match, the one with the highest index decides both the address and the permission result.
- R7: A lookup that matches no descriptor raises `rsp_fault`, keeps `rsp_hit` low and returns a physical address of zero. Exactly one of `rsp_hit` and `rsp_fault` is high in every response.
- R8: `req_acc` encodes 0 as read, 1 as write, 2 as execute and 3 as reserved. A reserved access always faults. `req_user`=1 checks the user bits and `req_user`=0 checks the supervisor bits. If the needed bit is clear, the lookup faults with a zero address.
- R9: Every lookup is answered exactly one cycle after `req_valid`. When no response is due, `rsp_valid`, `rsp_hit` and `rsp_fault` are low.
- R10: After reset, descriptor 0 maps logical 0x0000_0000 to 0x7FFF_FFFF one-to-one with all six permissions. Every other descriptor has size code 0, and all response outputs are low.
- R11: A permission fault from the winning descriptor stands even when a lower-index matching descriptor would allow the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor half write strobe |
| cfg_idx | input | 4 | Descriptor index to write |
| cfg_hi | input | 1 | 0 = lower half, 1 = upper half |
| cfg_wdata | input | 32 | Descriptor half data |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Logical address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| req_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | No match or permission denied |
| rsp_paddr | output | 36 | Physical address, zero on fault |

## Verification
The hardest case to reach is an address covered by two descriptors whose permissions disagree. Only the higher index may decide, so the unit must return a fault even though a lower descriptor would grant the access. The stimulus builds this case on purpose: a small supervisor-read-only window is placed inside a 2 GB full-permission window, and a write is issued into the overlap. A 4 GB descriptor in the top slot then covers every other window at once. A write issued in the same cycle as a lookup shows that the lookup still sees the old descriptor.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int LADDR_W  = 32;
  localparam int PADDR_W  = 36;
  localparam int PAGE_W   = 12;
  localparam int SIZE_W   = 5;
  localparam int PERM_W   = 6;
  localparam int MIN_CODE = 11;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_t;

  typedef struct packed {
    logic [LADDR_W-1:PAGE_W] lbase;
    logic [SIZE_W-1:0]       code;
    logic [PADDR_W-1:PAGE_W] pbase;
    logic [PERM_W-1:0]       perm;
  } seg_desc_t;
endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [IDX_W-1:0]        cfg_idx,
  input  logic                    cfg_hi,
  input  logic [31:0]             cfg_wdata,
  output seg_desc_t [NUM_SEG-1:0] descs
);
  logic unused_rsvd;
  assign unused_rsvd = ^cfg_wdata[7:6];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        descs[i] <= '0;
      end
      descs[0].code <= SIZE_W'(30);
      descs[0].perm <= '1;
    end else if (cfg_we) begin
      if (cfg_hi) begin
        descs[cfg_idx].pbase <= cfg_wdata[31:8];
        descs[cfg_idx].perm  <= cfg_wdata[5:0];
      end else begin
        descs[cfg_idx].lbase <= cfg_wdata[31:12];
        descs[cfg_idx].code  <= cfg_wdata[4:0];
      end
    end
  end
endmodule

// File: rtl/seg_match.sv
module seg_match
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16
) (
  input  seg_desc_t [NUM_SEG-1:0] descs,
  input  logic [LADDR_W-1:0]      addr,
  input  logic [1:0]              acc,
  input  logic                    user,
  output logic [NUM_SEG-1:0]      hit_vec,
  output logic [NUM_SEG-1:0]      ok_vec,
  output logic [PADDR_W-1:0]      phys [NUM_SEG]
);
  localparam int EXT_W = PADDR_W - LADDR_W;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic [LADDR_W:0]   wide;
    logic [LADDR_W-1:0] mask;
    logic [2:0]         pidx;
    logic               enabled;

    always_comb begin
      wide    = (33'd1 << ({1'b0, descs[g].code} + 6'd1)) - 33'd1;
      mask    = wide[LADDR_W-1:0];
      enabled = descs[g].code >= SIZE_W'(MIN_CODE);
      hit_vec[g] = enabled &&
        ((addr & ~mask) == ({descs[g].lbase, {PAGE_W{1'b0}}} & ~mask));
      phys[g] = ({descs[g].pbase, {PAGE_W{1'b0}}} & ~{{EXT_W{1'b0}}, mask})
              | {{EXT_W{1'b0}}, addr & mask};
      pidx = (user ? 3'd0 : 3'd3) + {1'b0, acc};
      ok_vec[g] = (acc != ACC_RSVD) && descs[g].perm[pidx];
    end
  end
endmodule

// File: rtl/seg_prio_pick.sv
module seg_prio_pick
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16
) (
  input  logic [NUM_SEG-1:0] hit_vec,
  input  logic [NUM_SEG-1:0] ok_vec,
  input  logic [PADDR_W-1:0] phys [NUM_SEG],
  output logic               win_hit,
  output logic               win_ok,
  output logic [PADDR_W-1:0] win_phys
);
  always_comb begin
    win_hit  = 1'b0;
    win_ok   = 1'b0;
    win_phys = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (hit_vec[i]) begin
        win_hit  = 1'b1;
        win_ok   = ok_vec[i];
        win_phys = phys[i];
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W  = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_hi,
  input  logic [31:0]        cfg_wdata,
  input  logic               req_valid,
  input  logic [LADDR_W-1:0] req_addr,
  input  logic [1:0]         req_acc,
  input  logic               req_user,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_fault,
  output logic [PADDR_W-1:0] rsp_paddr
);
  seg_desc_t [NUM_SEG-1:0] descs;
  logic [NUM_SEG-1:0]      hit_vec, ok_vec;
  logic [PADDR_W-1:0]      phys [NUM_SEG];
  logic                    win_hit, win_ok;
  logic [PADDR_W-1:0]      win_phys;

  seg_desc_bank #(.NUM_SEG(NUM_SEG)) u_bank (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .descs(descs)
  );

  seg_match #(.NUM_SEG(NUM_SEG)) u_match (
    .descs(descs), .addr(req_addr), .acc(req_acc), .user(req_user),
    .hit_vec(hit_vec), .ok_vec(ok_vec), .phys(phys)
  );

  seg_prio_pick #(.NUM_SEG(NUM_SEG)) u_pick (
    .hit_vec(hit_vec), .ok_vec(ok_vec), .phys(phys),
    .win_hit(win_hit), .win_ok(win_ok), .win_phys(win_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && win_hit && win_ok;
      rsp_fault <= req_valid && !(win_hit && win_ok);
      rsp_paddr <= (req_valid && win_hit && win_ok) ? win_phys : '0;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_fault,
  input logic [35:0] rsp_paddr
);
  p_answer_next_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_hit && !rsp_fault));
  p_one_outcome_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit ^ rsp_fault));
  p_fault_zero_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_paddr == 36'd0));
  p_offset_keep_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_paddr[11:0] == $past(req_addr[11:0])));
endmodule

bind seg_xlate seg_xlate_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
  .rsp_paddr(rsp_paddr)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic        cfg_hi = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [35:0] rsp_paddr;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_acc(req_acc), .req_user(req_user),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault),
    .rsp_paddr(rsp_paddr)
  );

  // {addr, acc, user, exp_hit, exp_paddr}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {32'h8000_1234, 2'd0, 1'b0, 1'b1, 36'h1_0000_1234},
    {32'h9000_0ABC, 2'd0, 1'b0, 1'b1, 36'h2_4000_0ABC},
    {32'h9000_0ABC, 2'd1, 1'b0, 1'b0, 36'h0_0000_0000},
    {32'h9001_0000, 2'd1, 1'b0, 1'b1, 36'h1_1001_0000},
    {32'h9000_FFFF, 2'd0, 1'b1, 1'b0, 36'h0_0000_0000},
    {32'h0000_4010, 2'd0, 1'b1, 1'b1, 36'h8_0000_0010},
    {32'h0000_4FFF, 2'd2, 1'b1, 1'b1, 36'h8_0000_0FFF},
    {32'h0000_4010, 2'd1, 1'b1, 1'b0, 36'h0_0000_0000},
    {32'h0000_4010, 2'd0, 1'b0, 1'b0, 36'h0_0000_0000},
    {32'h0000_5010, 2'd1, 1'b1, 1'b1, 36'h0_0000_5010},
    {32'h7FFF_FFFC, 2'd2, 1'b0, 1'b1, 36'h0_7FFF_FFFC},
    {32'h0000_3FFC, 2'd0, 1'b1, 1'b1, 36'h0_0000_3FFC}
  };
  localparam string VTAG [NV] = '{"R5", "R6", "R11", "R6", "R8", "R8",
                                  "R8", "R8", "R8", "R10", "R10", "R4"};

  task automatic wr(input logic [3:0] idx, input logic hi, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_hi = hi; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog(input logic [3:0] idx, input logic [31:0] lb,
                      input logic [4:0] code, input logic [35:0] pb,
                      input logic [5:0] perm);
    wr(idx, 1'b0, {lb[31:12], 7'd0, code});
    wr(idx, 1'b1, {pb[35:12], 2'd0, perm});
  endtask

  task automatic judge(input logic eh, input logic [35:0] ep, input string tag);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== eh || rsp_fault !== !eh ||
        rsp_paddr !== ep) begin
      fails++;
      $display("FAIL %s: got v=%0b hit=%0b fault=%0b paddr=%h, expected v=1 hit=%0b fault=%0b paddr=%h",
               tag, rsp_valid, rsp_hit, rsp_fault, rsp_paddr, eh, !eh, ep);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic [1:0] t, input logic u,
                      input logic eh, input logic [35:0] ep, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_acc = t; req_user = u;
    @(negedge clk);
    req_valid = 1'b0;
    judge(eh, ep, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: outputs low after reset
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0 || rsp_paddr !== '0) begin
      fails++;
      $display("FAIL R10: got v=%0b hit=%0b fault=%0b paddr=%h, expected all zero",
               rsp_valid, rsp_hit, rsp_fault, rsp_paddr);
    end
    look(32'h1234_5678, 2'd1, 1'b1, 1'b1, 36'h0_1234_5678, "R10");
    look(32'h8000_0000, 2'd0, 1'b0, 1'b0, 36'h0, "R7");
    // R9: no response when no request
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_fault !== 1'b0) begin
      fails++;
      $display("FAIL R9: got v=%0b hit=%0b fault=%0b, expected 0 0 0",
               rsp_valid, rsp_hit, rsp_fault);
    end

    // R1 R2 R3: program descriptors
    prog(4'd1, 32'h8000_0000, 5'd30, 36'h1_0000_0000, 6'h3F);
    prog(4'd2, 32'h9000_0000, 5'd15, 36'h2_4000_0000, 6'b001000);
    prog(4'd3, 32'h0000_4000, 5'd11, 36'h8_0000_0000, 6'b000101);

    for (int i = 0; i < NV; i++) begin
      look(VEC[i][71:40], VEC[i][39:38], VEC[i][37], VEC[i][36],
           VEC[i][35:0], VTAG[i]);
    end

    // R8: reserved access kind always faults
    look(32'h0000_5010, 2'd3, 1'b0, 1'b0, 36'h0, "R8");

    // R1: write and lookup in the same cycle use the old descriptor
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'd3; cfg_hi = 1'b0; cfg_wdata = 32'h0000_4000;
    req_valid = 1'b1; req_addr = 32'h0000_4010; req_acc = 2'd0; req_user = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    judge(1'b1, 36'h8_0000_0010, "R1");
    look(32'h0000_4010, 2'd0, 1'b1, 1'b1, 36'h0_0000_4010, "R1");

    // R4: size code below 11 disables; address then unmapped (R7)
    wr(4'd1, 1'b0, {20'h80000, 7'd0, 5'd10});
    look(32'h8000_0010, 2'd0, 1'b0, 1'b0, 36'h0, "R4");

    // R6 R4: 4 GB segment in the top slot overrides everything
    prog(4'd15, 32'h0000_0000, 5'd31, 36'h4_0000_0000, 6'b111000);
    look(32'h0000_5010, 2'd0, 1'b0, 1'b1, 36'h4_0000_5010, "R6");
    look(32'hFFFF_FFF0, 2'd1, 1'b0, 1'b1, 36'h4_FFFF_FFF0, "R4");
    look(32'h0000_5010, 2'd0, 1'b1, 1'b0, 36'h0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule